// File: doc/BRIEF.md
# Per-Lane Receive Error Counter

This block keeps receive error statistics for a multi-lane serial link that uses 8b/10b line coding. The character decoder of each lane reports several characters per clock, one per byte position of the lane word. For each character it gives the decoded byte, a control-character (K) indication, a running-disparity error flag and a not-in-table flag. A single input also shows when the link is still in code group synchronization. The block adds the errors it sees into one saturating counter per lane.

Three error classes are counted. The first is disparity errors. The second is characters that are not in the code table. The third is unexpected control characters, meaning any K character that is not from the K28 group. A control register can mask each class on its own, and it has a clear bit that holds every counter at zero. Software reads the counters and the control register through a plain synchronous register port. Writes take effect at the clock edge, and read data follows the address combinationally.

Top module: `lnkerr_stats`

## Requirements
- R1: The block has one counter per lane, CNT_W bits wide (32 by default). A synchronous active-high `rst` sets every counter to zero.
- R2: Lane n's counter reads at byte address 0x308 + n*0x20, zero-extended to 32 bits. Any address that is neither a lane counter nor the control register reads as zero.
- R3: The control register sits at address 0x244 and resets to zero. Bit 0 is the clear bit, bit 8 masks disparity errors, bit 9 masks not-in-table errors and bit 10 masks unexpected-K errors. Those four bits read back as written, and every other bit reads zero.
- R4: For every cycle in which control bit 0 is 1, all counters are zero at the following edge. They stay at zero until the bit is written back to 0.
- R5: Each character with its disparity flag set adds one to its lane's counter, unless bit 8 is set.
- R6: Each character with its not-in-table flag set adds one to its lane's counter, unless bit 9 is set.
- R7: A character with its K flag set adds one, unless bit 10 is set, when the low five bits of its byte differ from 5'b11100. A K character whose low five bits equal 5'b11100 (the K28 group, for example 0xBC) adds nothing.
- R8: While `lane_cgs` is 1, no counter changes.
- R9: All unmasked flags of all byte positions of a lane in one cycle are added together, and the sum appears one clock after the flags.
- R10: A counter that would pass its all-ones value stays at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_cgs | input | 1 | Link is in code group synchronization |
| rx_char | input | LANES*BYTES*8 | Decoded bytes; lane n, position b at bits (n*BYTES+b)*8 +: 8 |
| rx_is_k | input | LANES*BYTES | K-character flag per character |
| rx_disp_err | input | LANES*BYTES | Disparity error flag per character |
| rx_nit_err | input | LANES*BYTES | Not-in-table flag per character |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |

## Verification
The assertions assume that nothing is written to the register port while `rst` is high. They also assume that the per-lane increment in one cycle never exceeds the counter range, which holds whenever CNT_W is at least the width of 3*BYTES. The bench uses two lanes, two byte positions and an 8-bit counter, so saturation is reached within a few dozen cycles. It holds every flag low during register writes, so the masks and the clear bit only change between counted cycles. It sweeps every flag and byte combination, then every mask setting under a pseudo-random pattern, and it computes the expected count for each cycle arithmetically.

// File: rtl/lnkerr_pkg.sv
package lnkerr_pkg;

    localparam int unsigned CTRL_ADDR   = 32'h244;
    localparam int unsigned LANE_BASE   = 32'h308;
    localparam int unsigned LANE_STRIDE = 32'h20;

    localparam int CLR_BIT   = 0;
    localparam int MDISP_BIT = 8;
    localparam int MNIT_BIT  = 9;
    localparam int MUK_BIT   = 10;

    localparam logic [4:0] K28_LOW = 5'b11100;

    typedef struct packed {
        logic mask_uk;
        logic mask_nit;
        logic mask_disp;
        logic clear;
    } ctrl_t;

    typedef struct packed {
        logic disp;
        logic nit;
        logic uk;
    } char_err_t;

    function automatic logic unexpected_k(logic is_k, logic [7:0] ch);
        return is_k && (ch[4:0] != K28_LOW);
    endfunction

    function automatic logic [1:0] weigh(char_err_t e, ctrl_t c);
        return 2'(e.disp & ~c.mask_disp) + 2'(e.nit & ~c.mask_nit) + 2'(e.uk & ~c.mask_uk);
    endfunction

    function automatic logic [31:0] ctrl_to_word(ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[CLR_BIT]   = c.clear;
        w[MDISP_BIT] = c.mask_disp;
        w[MNIT_BIT]  = c.mask_nit;
        w[MUK_BIT]   = c.mask_uk;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(logic [31:0] w);
        ctrl_t c;
        c.clear     = w[CLR_BIT];
        c.mask_disp = w[MDISP_BIT];
        c.mask_nit  = w[MNIT_BIT];
        c.mask_uk   = w[MUK_BIT];
        return c;
    endfunction

endpackage

// File: rtl/lnkerr_lane_tally.sv
module lnkerr_lane_tally
    import lnkerr_pkg::*;
#(
    parameter int BYTES = 4,
    parameter int INC_W = 4
) (
    input  logic [BYTES*8-1:0] ch,
    input  logic [BYTES-1:0]   is_k,
    input  logic [BYTES-1:0]   disp,
    input  logic [BYTES-1:0]   nit,
    input  ctrl_t              ctrl,
    output logic [INC_W-1:0]   inc
);

    char_err_t errs [BYTES];

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign errs[b].disp = disp[b];
        assign errs[b].nit  = nit[b];
        assign errs[b].uk   = unexpected_k(is_k[b], ch[b*8 +: 8]);
    end

    always_comb begin
        inc = '0;
        for (int b = 0; b < BYTES; b++) begin
            inc = inc + INC_W'(weigh(errs[b], ctrl));
        end
    end

endmodule

// File: rtl/lnkerr_sat_cnt.sv
module lnkerr_sat_cnt #(
    parameter int CNT_W = 32,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             hold,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W:0] sum;

    assign sum = {1'b0, cnt} + (CNT_W + 1)'(inc);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (!hold) begin
            cnt <= sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/lnkerr_regs.sv
module lnkerr_regs
    import lnkerr_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [31:0]            wdata,
    input  logic [LANES*CNT_W-1:0] cnt_flat,
    output ctrl_t                  ctrl,
    output logic [31:0]            rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr && addr == ADDR_W'(CTRL_ADDR)) begin
            ctrl <= word_to_ctrl(wdata);
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CTRL_ADDR)) begin
            rdata = ctrl_to_word(ctrl);
        end
        for (int n = 0; n < LANES; n++) begin
            if (addr == ADDR_W'(LANE_BASE + n * LANE_STRIDE)) begin
                rdata = 32'(cnt_flat[n*CNT_W +: CNT_W]);
            end
        end
    end

endmodule

// File: rtl/lnkerr_stats.sv
module lnkerr_stats
    import lnkerr_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTES  = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     lane_cgs,
    input  logic [LANES*BYTES*8-1:0] rx_char,
    input  logic [LANES*BYTES-1:0]   rx_is_k,
    input  logic [LANES*BYTES-1:0]   rx_disp_err,
    input  logic [LANES*BYTES-1:0]   rx_nit_err,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata
);

    localparam int INC_W = $clog2(3 * BYTES + 1);

    ctrl_t                  ctrl_q;
    logic [LANES*CNT_W-1:0] cnt_flat;

    lnkerr_regs #(
        .LANES (LANES),
        .CNT_W (CNT_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .cnt_flat(cnt_flat),
        .ctrl    (ctrl_q),
        .rdata   (reg_rdata)
    );

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        logic [INC_W-1:0] inc;

        lnkerr_lane_tally #(
            .BYTES(BYTES),
            .INC_W(INC_W)
        ) u_tally (
            .ch  (rx_char[n*BYTES*8 +: BYTES*8]),
            .is_k(rx_is_k[n*BYTES +: BYTES]),
            .disp(rx_disp_err[n*BYTES +: BYTES]),
            .nit (rx_nit_err[n*BYTES +: BYTES]),
            .ctrl(ctrl_q),
            .inc (inc)
        );

        lnkerr_sat_cnt #(
            .CNT_W(CNT_W),
            .INC_W(INC_W)
        ) u_cnt (
            .clk (clk),
            .rst (rst),
            .clr (ctrl_q.clear),
            .hold(lane_cgs),
            .inc (inc),
            .cnt (cnt_flat[n*CNT_W +: CNT_W])
        );
    end

endmodule

// File: rtl/lnkerr_stats_chk.sv
module lnkerr_stats_chk
    import lnkerr_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 12
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   lane_cgs,
    input logic                   reg_wr,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic [31:0]            reg_wdata,
    input logic [3:0]             ctrl_bits,
    input logic [LANES*CNT_W-1:0] cnt_flat
);

    a_r1_reset_zero: assert property (@(posedge clk)
        $past(rst) |-> cnt_flat == '0);

    a_r3_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(reg_wr && reg_addr == ADDR_W'(CTRL_ADDR))
        |-> ctrl_bits == {$past(reg_wdata[MUK_BIT]), $past(reg_wdata[MNIT_BIT]),
                          $past(reg_wdata[MDISP_BIT]), $past(reg_wdata[CLR_BIT])});

    a_r4_clear_holds: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(ctrl_bits[0]) |-> cnt_flat == '0);

    a_r8_cgs_frozen: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(ctrl_bits[0]) && $past(lane_cgs) |-> $stable(cnt_flat));

    for (genvar n = 0; n < LANES; n++) begin : g_lane_chk
        a_r9_no_decrease: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) && !$past(ctrl_bits[0])
            |-> cnt_flat[n*CNT_W +: CNT_W] >= $past(cnt_flat[n*CNT_W +: CNT_W]));

        a_r10_saturate_holds: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) && !$past(ctrl_bits[0]) && $past(cnt_flat[n*CNT_W +: CNT_W]) == {CNT_W{1'b1}}
            |-> cnt_flat[n*CNT_W +: CNT_W] == {CNT_W{1'b1}});
    end

endmodule

bind lnkerr_stats lnkerr_stats_chk #(
    .LANES (LANES),
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lane_cgs (lane_cgs),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .ctrl_bits(ctrl_q),
    .cnt_flat (cnt_flat)
);

// File: tb/tb_lnkerr_stats.sv
`timescale 1ns/1ps
module tb_lnkerr_stats;

    localparam int LANES  = 2;
    localparam int BYTES  = 2;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 12;
    localparam int MAXC   = 255;
    localparam logic [ADDR_W-1:0] A_CTRL = 12'h244;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     lane_cgs = 1'b0;
    logic [LANES*BYTES*8-1:0] rx_char = '0;
    logic [LANES*BYTES-1:0]   rx_is_k = '0;
    logic [LANES*BYTES-1:0]   rx_disp_err = '0;
    logic [LANES*BYTES-1:0]   rx_nit_err = '0;
    logic                     reg_wr = 1'b0;
    logic [ADDR_W-1:0]        reg_addr = '0;
    logic [31:0]              reg_wdata = '0;
    logic [31:0]              reg_rdata;

    int n_checks = 0;
    int n_errors = 0;
    int exp_cnt [LANES];
    logic m_disp = 0, m_nit = 0, m_uk = 0, m_clr = 0;
    logic [15:0] lf = 16'hACE1;

    lnkerr_stats #(
        .LANES (LANES),
        .BYTES (BYTES),
        .CNT_W (CNT_W),
        .ADDR_W(ADDR_W)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .lane_cgs   (lane_cgs),
        .rx_char    (rx_char),
        .rx_is_k    (rx_is_k),
        .rx_disp_err(rx_disp_err),
        .rx_nit_err (rx_nit_err),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata)
    );

    always #4 clk = ~clk;

    task automatic read_chk(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        n_checks++;
        if (reg_rdata !== exp) begin
            n_errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic check_lanes(input string tag);
        for (int l = 0; l < LANES; l++) begin
            read_chk(ADDR_W'(12'h308 + l * 12'h20), 32'(exp_cnt[l]), tag);
        end
    endtask

    // one counted cycle: nibble per character = {K28 select, K flag, not-in-table, disparity}
    task automatic apply(input logic [15:0] pat, input logic cgs);
        int inc [LANES];
        for (int l = 0; l < LANES; l++) begin
            inc[l] = 0;
            for (int b = 0; b < BYTES; b++) begin
                int i;
                logic [3:0] nib;
                i = l * BYTES + b;
                nib = pat[i*4 +: 4];
                rx_disp_err[i] = nib[0];
                rx_nit_err[i]  = nib[1];
                rx_is_k[i]     = nib[2];
                rx_char[i*8 +: 8] = nib[3] ? 8'hBC : 8'hFB;
                inc[l] += int'(nib[0] & ~m_disp) + int'(nib[1] & ~m_nit)
                        + int'(nib[2] & ~nib[3] & ~m_uk);
            end
        end
        lane_cgs = cgs;
        @(posedge clk);
        for (int l = 0; l < LANES; l++) begin
            if (m_clr) exp_cnt[l] = 0;
            else if (!cgs) exp_cnt[l] = (exp_cnt[l] + inc[l] > MAXC) ? MAXC : exp_cnt[l] + inc[l];
        end
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [31:0] d);
        rx_disp_err = '0;
        rx_nit_err  = '0;
        rx_is_k     = '0;
        lane_cgs    = 1'b0;
        reg_wr    = 1'b1;
        reg_addr  = A_CTRL;
        reg_wdata = d;
        @(posedge clk);
        if (m_clr) for (int l = 0; l < LANES; l++) exp_cnt[l] = 0;
        m_clr = d[0]; m_disp = d[8]; m_nit = d[9]; m_uk = d[10];
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic clear_all();
        reg_write(32'h1);
        apply(16'h0, 1'b0);
        reg_write(32'h0);
    endtask

    task automatic step_lf();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int l = 0; l < LANES; l++) exp_cnt[l] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        read_chk(A_CTRL, 32'h0, "R3 reset value");
        check_lanes("R1 reset");
        read_chk(12'h348, 32'h0, "R2 unmapped lane slot");
        read_chk(12'h300, 32'h0, "R2 unmapped address");

        // control readback
        reg_write(32'hFFFF_FFFE);
        read_chk(A_CTRL, 32'h0000_0700, "R3 masks readback");
        reg_write(32'h0000_0101);
        read_chk(A_CTRL, 32'h0000_0101, "R3 partial readback");
        reg_write(32'h0);
        read_chk(A_CTRL, 32'h0, "R3 cleared");
        apply(16'h0, 1'b0);
        check_lanes("R4 after clear");

        // every flag/byte combination per lane, no masks
        for (int p = 0; p < 256; p++) begin
            apply({8'(p * 37 + 11), 8'(p)}, 1'b0);
            check_lanes("R5 R6 R7 R9 sweep");
            if (p % 16 == 15) clear_all();
        end

        // every mask setting with pseudo-random flags
        for (int m = 0; m < 8; m++) begin
            reg_write(32'(m) << 8);
            for (int s = 0; s < 40; s++) begin
                step_lf();
                apply(lf, 1'b0);
                check_lanes("R5 R6 R7 mask sweep");
            end
            reg_write(32'(m) << 8 | 32'h1);
            apply(16'h0, 1'b0);
            reg_write(32'h0);
        end

        // K28 group adds nothing, other K adds one per character
        apply(16'hCCCC, 1'b0);
        check_lanes("R7 K28 ignored");
        apply(16'h4444, 1'b0);
        check_lanes("R7 non-K28 counted");

        // synchronization phase freezes counters
        for (int s = 0; s < 20; s++) begin
            step_lf();
            apply(lf | 16'h1111, 1'b1);
            check_lanes("R8 cgs freeze");
        end

        // clear bit held
        reg_write(32'h1);
        for (int s = 0; s < 10; s++) begin
            apply(16'h7777, 1'b0);
            check_lanes("R4 clear held");
        end
        reg_write(32'h0);

        // saturation at all ones
        for (int s = 0; s < 50; s++) begin
            apply(16'h7777, 1'b0);
            check_lanes("R10 saturate");
        end
        read_chk(12'h308, 32'(MAXC), "R10 lane0 at max");
        read_chk(12'h328, 32'(MAXC), "R10 lane1 at max");

        finish_run();
    end

endmodule